// File: doc/BRIEF.md
# Register Write Port Conflict Resolver

This block sequences a five-stage in-order pipeline (fetch, decode, execute, memory, write-back) whose register file has a single write port. It accepts one decoded instruction class per cycle and moves each accepted instruction through the five stages. It also makes sure that at most one instruction drives the register write port in any cycle. The four classes are register-to-register (R-type), load, store and branch. A load writes the register file in its fifth stage. An R-type would naturally write in its fourth stage, so an R-type that follows a load by one cycle would hit the port in the same cycle as the load.

A mode input picks how that collision is avoided. In bubble mode (`mode_delay` = 0), R-types write in stage 4. When such an R-type is offered directly behind a stage-5 writer, the block holds it for one cycle and starts nothing, so one issue slot is lost. In delay mode (`mode_delay` = 1), an R-type passes through the memory stage idle and writes in stage 5 like a load, so issue never stalls. The mode is captured with each instruction as it issues. The outputs are the per-stage valid and class vectors, the register write enable, the data-memory write strobe for stores, the PC-load strobe for branches, and an issue stall.

Top module: `wport_sched`

## Requirements
- R1: While reset is asserted, and until the first instruction issues after reset, every stage is empty and `wr_en`, `dmem_we`, `pc_load` and `issue_stall` are 0.
- R2: Class codes on `in_class` are 00 R-type, 01 load, 10 store, 11 branch. An accepted instruction is present in stage 1 (`stage_valid[0]`) in the cycle after the clock edge that accepts it. It then advances one stage per cycle. Stage k (0-based) shows its class on `stage_class[2k+1:2k]`, and that field is 00 when the stage is empty.
- R3: A load drives `wr_en` in the cycle it occupies stage 5.
- R4: An R-type accepted with `mode_delay` = 0 drives `wr_en` in the cycle it occupies stage 4.
- R5: An R-type accepted with `mode_delay` = 1 does nothing in stage 4 and drives `wr_en` in the cycle it occupies stage 5.
- R6: With `mode_delay` = 0, an R-type offered while stage 1 holds an instruction that will write in stage 5 sees `issue_stall` = 1 and is not accepted. Stage 1 is empty in the next cycle, and the held R-type is accepted one cycle later.
- R7: With `mode_delay` = 1, `issue_stall` stays 0, so one instruction is accepted per cycle.
- R8: No two in-flight instructions request the register write port in the same cycle.
- R9: A store raises `dmem_we` in the cycle it occupies stage 4 and never drives `wr_en`.
- R10: A branch raises `pc_load` in the cycle it occupies stage 3 and never drives `wr_en`.
- R11: A bubble or empty slot shows `stage_valid` 0 and causes no `wr_en`, `dmem_we` or `pc_load`.
- R12: Each instruction keeps the write stage set by the mode at its acceptance, even if `mode_delay` changes while it is in flight. The stall rule of R6 uses the write stage of the actual occupant of stage 1.
- R13: With a constant mode and no input gaps, N instructions are accepted in N cycles in delay mode. In bubble mode they take N plus the number of R-types that directly follow a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_delay | input | 1 | 0: bubble policy, 1: R-type write delayed to stage 5 |
| in_valid | input | 1 | An instruction class is offered this cycle |
| in_class | input | 2 | Offered class: 00 R-type, 01 load, 10 store, 11 branch |
| issue_stall | output | 1 | Offered instruction is held this cycle |
| stage_valid | output | 5 | Occupancy of stages 1..5 (bit 0 = stage 1) |
| stage_class | output | 10 | Class per stage, two bits each, stage 1 in the low bits |
| wr_en | output | 1 | Register file write port enable |
| dmem_we | output | 1 | Data memory write strobe (store in stage 4) |
| pc_load | output | 1 | PC load strobe (branch in stage 3) |

## Verification
The hardest situation to reach is a mode change with writers in flight. An R-type accepted under delay mode must still push back a following R-type accepted under bubble mode. An early R-type must sit harmlessly in front of a late load. The random phase switches `mode_delay` every few instructions and inserts occasional idle gaps. Directed sequences cover load-then-R-type in both modes and a delayed R-type followed by a bubble-mode R-type. A per-cycle model of expected write, store and branch strobes catches any double write or misplaced write. Whole-sequence cycle counts are compared with the count predicted for each policy.

// File: rtl/wps_pkg.sv
package wps_pkg;
  localparam int unsigned NSTG    = 5;
  localparam int unsigned CLS_W   = 2;
  localparam int unsigned ST_EXEC = 2;
  localparam int unsigned ST_MEM  = 3;
  localparam int unsigned ST_WB   = NSTG - 1;

  typedef enum logic [CLS_W-1:0] {
    CLS_ALU    = 2'b00,
    CLS_LOAD   = 2'b01,
    CLS_STORE  = 2'b10,
    CLS_BRANCH = 2'b11
  } icls_e;

  typedef struct packed {
    logic  valid;
    icls_e cls;
    logic  late;
  } slot_t;

  function automatic logic cls_writes(input icls_e c);
    return (c == CLS_ALU) || (c == CLS_LOAD);
  endfunction
endpackage

// File: rtl/wps_rst_sync.sv
module wps_rst_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [DEPTH-1:0] sync_q;
  logic [DEPTH-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[DEPTH-1];
endmodule

// File: rtl/wps_issue_ctl.sv
module wps_issue_ctl
  import wps_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  mode_delay,
  input  logic  in_valid,
  input  icls_e in_cls,
  input  logic  head_valid,
  input  logic  head_late,
  output logic  issue_stall,
  output slot_t new_slot
);
  logic new_late;
  logic new_early;
  logic issue_en;

  always_comb begin
    new_late    = (in_cls == CLS_LOAD) || ((in_cls == CLS_ALU) && mode_delay);
    new_early   = (in_cls == CLS_ALU) && !mode_delay;
    issue_stall = in_valid && new_early && head_valid && head_late;
    issue_en    = in_valid && !issue_stall;
    new_slot    = '0;
    if (issue_en) begin
      new_slot.valid = 1'b1;
      new_slot.cls   = in_cls;
      new_slot.late  = new_late;
    end
  end

  assert_no_stall_in_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
    issue_stall |-> !mode_delay);

  assert_bubble_after_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    issue_stall |=> !head_valid);

  assert_stall_needs_offer_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> !issue_stall);
endmodule

// File: rtl/wps_pipe.sv
module wps_pipe
  import wps_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  slot_t            new_slot,
  output slot_t [NSTG-1:0] stages
);
  slot_t q   [NSTG];
  slot_t nxt [NSTG];
  logic  en  [NSTG];

  always_comb begin
    nxt[0] = new_slot;
    for (int k = 1; k < NSTG; k++) nxt[k] = q[k-1];
    for (int k = 0; k < NSTG; k++) en[k] = nxt[k].valid || q[k].valid;
  end

  for (genvar k = 0; k < NSTG; k++) begin : g_stg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q[k] <= '0;
      else if (en[k]) q[k] <= nxt[k];
    end
    assign stages[k] = q[k];

    assert_empty_slot_clean_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !q[k].valid |-> (q[k].cls == CLS_ALU) && !q[k].late);
  end

  for (genvar k = 1; k < NSTG; k++) begin : g_adv
    assert_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
      q[k-1].valid |=> q[k].valid && (q[k].cls == $past(q[k-1].cls)));
  end
endmodule

// File: rtl/wps_port_ctl.sv
module wps_port_ctl
  import wps_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  exec_valid,
  input  icls_e exec_cls,
  input  slot_t mem_slot,
  input  slot_t wb_slot,
  output logic  wr_en,
  output logic  dmem_we,
  output logic  pc_load
);
  logic early_req;
  logic late_req;

  always_comb begin
    early_req = mem_slot.valid && (mem_slot.cls == CLS_ALU) && !mem_slot.late;
    late_req  = wb_slot.valid && wb_slot.late;
    wr_en     = early_req || late_req;
    dmem_we   = mem_slot.valid && (mem_slot.cls == CLS_STORE);
    pc_load   = exec_valid && (exec_cls == CLS_BRANCH);
  end

  assert_single_writer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({early_req, late_req}) <= 1);

  assert_store_never_writes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_slot.valid && (wb_slot.cls == CLS_STORE)) |-> !wb_slot.late);

  assert_branch_never_writes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_slot.valid && (wb_slot.cls == CLS_BRANCH)) |-> !wb_slot.late);

  assert_load_writes_late_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_slot.valid && (wb_slot.cls == CLS_LOAD)) |-> wr_en);
endmodule

// File: rtl/wport_sched.sv
module wport_sched
  import wps_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mode_delay,
  input  logic                  in_valid,
  input  logic [CLS_W-1:0]      in_class,
  output logic                  issue_stall,
  output logic [NSTG-1:0]       stage_valid,
  output logic [NSTG*CLS_W-1:0] stage_class,
  output logic                  wr_en,
  output logic                  dmem_we,
  output logic                  pc_load
);
  logic             rst_n_sync;
  slot_t            new_slot;
  slot_t [NSTG-1:0] stages;

  wps_rst_sync #(.DEPTH(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_sync)
  );

  wps_issue_ctl u_issue (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .mode_delay  (mode_delay),
    .in_valid    (in_valid),
    .in_cls      (icls_e'(in_class)),
    .head_valid  (stages[0].valid),
    .head_late   (stages[0].late),
    .issue_stall (issue_stall),
    .new_slot    (new_slot)
  );

  wps_pipe u_pipe (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .new_slot (new_slot),
    .stages   (stages)
  );

  wps_port_ctl u_port (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .exec_valid (stages[ST_EXEC].valid),
    .exec_cls   (stages[ST_EXEC].cls),
    .mem_slot   (stages[ST_MEM]),
    .wb_slot    (stages[ST_WB]),
    .wr_en      (wr_en),
    .dmem_we    (dmem_we),
    .pc_load    (pc_load)
  );

  for (genvar k = 0; k < NSTG; k++) begin : g_out
    assign stage_valid[k]               = stages[k].valid;
    assign stage_class[k*CLS_W +: CLS_W] = stages[k].cls;

    assert_late_only_writers_R12: assert property (@(posedge clk) disable iff (!rst_n_sync)
      stages[k].late |-> stages[k].valid && cls_writes(stages[k].cls));
  end
endmodule

// File: tb/wport_sched_bench.sv
module wport_sched_bench;
  localparam int AW = 4096;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_delay = 1'b0;
  logic       in_valid = 1'b0;
  logic [1:0] in_class = 2'b00;
  logic       issue_stall;
  logic [4:0] stage_valid;
  logic [9:0] stage_class;
  logic       wr_en, dmem_we, pc_load;

  wport_sched u_wport_sched (
    .clk(clk), .rst_n(rst_n), .mode_delay(mode_delay), .in_valid(in_valid),
    .in_class(in_class), .issue_stall(issue_stall), .stage_valid(stage_valid),
    .stage_class(stage_class), .wr_en(wr_en), .dmem_we(dmem_we), .pc_load(pc_load)
  );

  always #2 clk = ~clk;

  int pe = 0;
  always @(posedge clk) pe <= pe + 1;

  int  n_chk = 0, n_fail = 0, cyc_n = 0;
  bit  done_flag = 0;
  bit  exp_wr [AW];
  bit  exp_dm [AW];
  bit  exp_pc [AW];
  logic [4:0] exp_sv [AW];
  logic [9:0] exp_sc [AW];
  int  last_issue = -10;
  bit  last_late = 0;
  logic [1:0] seq [16];

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, pe, act, expv);
    end
  endtask

  task automatic record(input int p, input logic [1:0] c, input bit m);
    for (int k = 0; k < 5; k++) begin
      exp_sv[(p+k)%AW][k] = 1'b1;
      exp_sc[(p+k)%AW][2*k +: 2] = c;
    end
    if (c == 2'b00 && !m) exp_wr[(p+3)%AW] = 1'b1;                 // R4
    if (c == 2'b01 || (c == 2'b00 && m)) exp_wr[(p+4)%AW] = 1'b1;  // R3 R5
    if (c == 2'b10) exp_dm[(p+3)%AW] = 1'b1;                       // R9
    if (c == 2'b11) exp_pc[(p+2)%AW] = 1'b1;                       // R10
  endtask

  task automatic check_outputs();
    int i;
    i = pe % AW;
    chk(wr_en == exp_wr[i], "R3 R4 R5 R8 wr_en", wr_en, exp_wr[i]);
    chk(dmem_we == exp_dm[i], "R9 dmem_we", dmem_we, exp_dm[i]);
    chk(pc_load == exp_pc[i], "R10 pc_load", pc_load, exp_pc[i]);
    chk(stage_valid == exp_sv[i], "R2 R11 stage_valid", stage_valid, exp_sv[i]);
    chk(stage_class == exp_sc[i], "R2 stage_class", stage_class, exp_sc[i]);
  endtask

  task automatic idle(input int n);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      check_outputs();
      in_valid = 1'b0;
      #1;
      chk(issue_stall == 1'b0, "R11 idle stall", issue_stall, 0);
    end
  endtask

  task automatic send(input logic [1:0] c, input bit m);
    bit done;
    bit es;
    done = 0;
    while (!done) begin
      @(negedge clk);
      check_outputs();
      mode_delay = m; in_valid = 1'b1; in_class = c;
      #1;
      es = !m && c == 2'b00 && last_late && (last_issue == pe);   // R6 R12
      chk(issue_stall == es, m ? "R7 issue_stall" : "R6 R12 issue_stall", issue_stall, es);
      if (!issue_stall) begin
        record(pe + 1, c, m);
        last_issue = pe + 1;
        last_late  = (c == 2'b01) || (c == 2'b00 && m);
        done = 1;
      end
      cyc_n++;
    end
  endtask

  function automatic int exp_cycles(input int len, input bit m);
    int n;
    n = len;
    if (!m)
      for (int i = 1; i < len; i++)
        if (seq[i] == 2'b00 && seq[i-1] == 2'b01) n++;
    return n;
  endfunction

  task automatic run_seq(input int len, input bit m, input string tag);
    int c0, got, want;
    c0 = cyc_n;
    for (int i = 0; i < len; i++) send(seq[i], m);
    got = cyc_n - c0;
    want = exp_cycles(len, m);
    chk(got == want, tag, got, want);
    idle(6);
  endtask

  initial begin
    for (int i = 0; i < AW; i++) begin exp_sv[i] = '0; exp_sc[i] = '0; end
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs empty while reset is held
    chk(stage_valid == 5'b0 && !wr_en && !dmem_we && !pc_load && !issue_stall,
        "R1 reset state", stage_valid, 0);
    rst_n = 1'b1;
    idle(4);

    // Directed: load then R-type, bubble mode (R6 R13)
    seq[0] = 2'b01; seq[1] = 2'b00; seq[2] = 2'b00; seq[3] = 2'b01; seq[4] = 2'b00;
    run_seq(5, 1'b0, "R13 bubble cycle count");
    // Same sequence in delay mode (R7 R13)
    run_seq(5, 1'b1, "R13 delay cycle count");
    // Store and branch timing mixed with writers (R9 R10)
    seq[0] = 2'b10; seq[1] = 2'b11; seq[2] = 2'b01; seq[3] = 2'b10; seq[4] = 2'b11; seq[5] = 2'b00;
    run_seq(6, 1'b0, "R9 R10 mixed count");
    // Mode change in flight: delayed R-type then bubble-mode R-type (R12)
    send(2'b00, 1'b1); send(2'b00, 1'b0); send(2'b00, 1'b0);
    idle(6);
    // Early R-type ahead of a late load: no stall (R12)
    send(2'b00, 1'b0); send(2'b01, 1'b1); send(2'b00, 1'b1);
    idle(6);
    // Gap between load and R-type removes the stall (R6)
    send(2'b01, 1'b0); idle(1); send(2'b00, 1'b0);
    idle(6);

    // Random mix with mode switches and gaps
    for (int b = 0; b < 100; b++) begin
      bit m;
      m = $urandom_range(0, 1);
      for (int j = 0; j < 8; j++) begin
        send(2'($urandom_range(0, 3)), m);
        if ($urandom_range(0, 9) == 0) idle(1);
      end
    end
    idle(8);

    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule